// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of a segmented current-steering converter. A 12-bit sample word enters together with a latch-enable strobe. The word is split into three drive groups: the top four bits become a 15-line thermometer code, the next two bits stay as binary-weighted lines, and the low six bits go out unchanged to drive a binary ladder. The top-group decode and the matching delay on the other groups run as a fixed number of clocked stages. The latch-enable strobe passes through the same stages, so all groups reach the output latches in the same cycle.

The output latches are transparent while the delayed strobe is low and hold their value while it is high. For checking purposes the block also reports two integer currents in LSB units. One is the current on the true output and the other is the current on the complementary output. Together they always make up full scale minus one LSB.

An elaboration option puts an input register in front of the pipeline. This register loads the word only while latch enable is high. The latches therefore see data that was settled before they open, which gives edge-triggered operation.

Top module: `seg_dac_front`

## Requirements
- R1: `word_in[11]` is the most significant bit and `word_in[0]` the least. With the latches open, `cur_pos` equals the input code as an unsigned integer.
- R2: When the top four bits `word_in[11:8]` have value k, thermometer line `seg_lines[i]` is 1 exactly when i < k. This leaves all lines low for k=0 and all 15 lines high for k=15.
- R3: `bin_lines[1]` follows `word_in[7]` and `bin_lines[0]` follows `word_in[6]`, with no decoding.
- R4: `ladder_lines[5:0]` follows `word_in[5:0]` bit for bit.
- R5: With the default two pipeline stages, a word driven together with latch enable low appears at every output after exactly two rising clock edges. Before the second edge, the outputs keep their previous value.
- R6: Latch enable takes effect with the same two-edge delay as the data. While the delayed strobe stays high, every output holds the word that was present when the strobe was last low.
- R7: All ones gives `cur_pos`=4095 and `cur_neg`=0. All zeros gives `cur_pos`=0 and `cur_neg`=4095.
- R8: `cur_pos + cur_neg` is 4095 for every code. A thermometer line weighs 256, `bin_lines[1]` weighs 128, `bin_lines[0]` weighs 64, and ladder bit j weighs 2^j.
- R9: A synchronous active-high `rst` clears all stages and latches. While it is asserted and after its release, every output line reads 0 and `cur_pos` reads 0 until new data arrives.
- R10: With `EDGE_MODE`=1, the input register loads `word_in` only on edges where `latch_en` is 1. A word driven only while `latch_en` is 0 never reaches the outputs, and captured data arrives three edges after capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 12 | Sample word, bit 11 most significant |
| latch_en | input | 1 | Latch strobe: latches open when low, hold when high |
| seg_lines | output | 15 | Thermometer lines for the top four bits |
| bin_lines | output | 2 | Binary-weighted middle bits |
| ladder_lines | output | 6 | Low bits to the ladder |
| cur_pos | output | 12 | True-output current in LSB units |
| cur_neg | output | 12 | Complementary-output current in LSB units |

## Verification
The hold check assumes that the strobe seen by the latches changes only on clock edges and that `rst` is a clean synchronous level. The bench changes `word_in` and `latch_en` only on falling edges, so each value is taken at a single rising edge. The full-scale and thermometer-shape checks assume the decoder receives a binary top field, so the bench never drives unknown bits after reset. Stimulus codes include both extremes, the midscale step 0x7FF to 0x800, and codes that mix the groups, so that each weight and bit position contributes to the expected current.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
   // number of thermometer lines produced from an n-bit field
   function automatic int therm_count(input int n);
      return (1 << n) - 1;
   endfunction
endpackage

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
   parameter int IN_W  = 4,
   localparam int OUT_N = seg_dac_pkg::therm_count(IN_W)
) (
   input  logic [IN_W-1:0]  code,
   output logic [OUT_N-1:0] lines
);
   generate
      for (genvar i = 0; i < OUT_N; i++) begin : g_line
         assign lines[i] = (code > IN_W'(i));
      end
   endgenerate
endmodule

// File: rtl/seg_dac_pipe.sv
module seg_dac_pipe #(
   parameter int W = 8,
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [N];

   generate
      for (genvar s = 0; s < N; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst)
               stage[s] <= '0;
            else if (s == 0)
               stage[s] <= d;
            else
               stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage[N-1];
endmodule

// File: rtl/seg_dac_hold.sv
module seg_dac_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         strobe,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] kept;

   always_ff @(posedge clk) begin
      if (rst)
         kept <= '0;
      else if (!strobe)
         kept <= d;
   end

   // open while strobe low, opaque while high
   assign q = strobe ? kept : d;

   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
      (strobe && $past(strobe)) |-> $stable(q));
endmodule

// File: rtl/seg_dac_weigh.sv
module seg_dac_weigh #(
   parameter int TH_N  = 15,
   parameter int MID_W = 2,
   parameter int LSB_W = 6,
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TH_N-1:0]   therm,
   input  logic [MID_W-1:0]  mid,
   input  logic [LSB_W-1:0]  ladder,
   output logic [WORD_W-1:0] i_pos,
   output logic [WORD_W-1:0] i_neg
);
   localparam int TW = 1 << (MID_W + LSB_W);
   localparam logic [WORD_W-1:0] FS = '1;

   logic [WORD_W-1:0] acc;

   always_comb begin
      acc = WORD_W'(ladder);
      acc = acc + (WORD_W'(mid) << LSB_W);
      for (int i = 0; i < TH_N; i++)
         if (therm[i]) acc = acc + WORD_W'(TW);
   end

   assign i_pos = acc;
   assign i_neg = FS - acc;

   assert_full_scale_R7: assert property (@(posedge clk) disable iff (rst)
      (&therm && &mid && &ladder) |-> (i_neg == '0 && i_pos == FS));
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
   parameter int MSB_W      = 4,
   parameter int MID_W      = 2,
   parameter int LSB_W      = 6,
   parameter int DLY_STAGES = 2,
   parameter bit EDGE_MODE  = 1'b0,
   localparam int WORD_W = MSB_W + MID_W + LSB_W,
   localparam int TH_N   = seg_dac_pkg::therm_count(MSB_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] word_in,
   input  logic              latch_en,
   output logic [TH_N-1:0]   seg_lines,
   output logic [MID_W-1:0]  bin_lines,
   output logic [LSB_W-1:0]  ladder_lines,
   output logic [WORD_W-1:0] cur_pos,
   output logic [WORD_W-1:0] cur_neg
);
   localparam int BUS_W = 1 + TH_N + MID_W + LSB_W;

   generate
      if (DLY_STAGES < 1) begin : g_bad_dly
         $error("DLY_STAGES must be at least 1");
      end
      if (MSB_W < 1 || MSB_W > 6) begin : g_bad_msb
         $error("MSB_W must be 1..6");
      end
   endgenerate

   logic [WORD_W-1:0] word_f;
   logic              le_f;

   generate
      if (EDGE_MODE) begin : g_edge
         logic [WORD_W-1:0] word_r;
         logic              le_r;
         always_ff @(posedge clk) begin
            if (rst) begin
               word_r <= '0;
               le_r   <= 1'b0;
            end else begin
               le_r <= latch_en;
               if (latch_en) word_r <= word_in;
            end
         end
         assign word_f = word_r;
         assign le_f   = le_r;
      end else begin : g_level
         assign word_f = word_in;
         assign le_f   = latch_en;
      end
   endgenerate

   logic [TH_N-1:0] therm_d;

   seg_dac_therm #(.IN_W(MSB_W)) u_therm (
      .code  (word_f[WORD_W-1 -: MSB_W]),
      .lines (therm_d)
   );

   logic [BUS_W-1:0] bus_in, bus_out;
   assign bus_in = {le_f, therm_d, word_f[LSB_W +: MID_W], word_f[LSB_W-1:0]};

   // data groups and strobe share one delay chain
   seg_dac_pipe #(.W(BUS_W), .N(DLY_STAGES)) u_pipe (
      .clk (clk),
      .rst (rst),
      .d   (bus_in),
      .q   (bus_out)
   );

   logic              le_q;
   logic [BUS_W-2:0]  held;
   assign le_q = bus_out[BUS_W-1];

   seg_dac_hold #(.W(BUS_W-1)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .strobe (le_q),
      .d      (bus_out[BUS_W-2:0]),
      .q      (held)
   );

   assign seg_lines    = held[MID_W+LSB_W +: TH_N];
   assign bin_lines    = held[LSB_W +: MID_W];
   assign ladder_lines = held[LSB_W-1:0];

   seg_dac_weigh #(.TH_N(TH_N), .MID_W(MID_W), .LSB_W(LSB_W), .WORD_W(WORD_W)) u_weigh (
      .clk    (clk),
      .rst    (rst),
      .therm  (seg_lines),
      .mid    (bin_lines),
      .ladder (ladder_lines),
      .i_pos  (cur_pos),
      .i_neg  (cur_neg)
   );

   assert_therm_shape_R2: assert property (@(posedge clk) disable iff (rst)
      ((seg_lines & (seg_lines + TH_N'(1))) == '0));

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (cur_pos == '0 && seg_lines == '0));
endmodule

// File: tb/sim_seg_dac_front.sv
module sim_seg_dac_front;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] word_in = '0;
   logic        latch_en = 1'b0;
   logic [14:0] seg_lines, seg1;
   logic [1:0]  bin_lines, bin1;
   logic [5:0]  ladder_lines, lad1;
   logic [11:0] cur_pos, cur_neg, pos1, neg1;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   seg_dac_front u0 (
      .clk(clk), .rst(rst), .word_in(word_in), .latch_en(latch_en),
      .seg_lines(seg_lines), .bin_lines(bin_lines), .ladder_lines(ladder_lines),
      .cur_pos(cur_pos), .cur_neg(cur_neg)
   );

   seg_dac_front #(.EDGE_MODE(1'b1)) u1 (
      .clk(clk), .rst(rst), .word_in(word_in), .latch_en(latch_en),
      .seg_lines(seg1), .bin_lines(bin1), .ladder_lines(lad1),
      .cur_pos(pos1), .cur_neg(neg1)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [14:0] therm_of(input logic [11:0] c);
      return 15'((32'd1 << c[11:8]) - 1);
   endfunction

   task automatic drive(input logic [11:0] c, input logic le);
      @(negedge clk);
      word_in  = c;
      latch_en = le;
   endtask

   task automatic check_word(input logic [11:0] c, input string req);
      chk(seg_lines == therm_of(c), {req, " R2 seg"}, seg_lines, therm_of(c));
      chk(bin_lines == c[7:6], {req, " R3 bin"}, bin_lines, c[7:6]);
      chk(ladder_lines == c[5:0], {req, " R4 ladder"}, ladder_lines, c[5:0]);
      chk(cur_pos == c, {req, " R1 pos"}, cur_pos, c);
      chk(int'(cur_pos) + int'(cur_neg) == 4095, {req, " R8 sum"},
          int'(cur_pos) + int'(cur_neg), 4095);
   endtask

   task automatic t_reset;
      word_in = 12'hFFF; latch_en = 1'b0; rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(seg_lines == 0 && cur_pos == 0, "R9 in reset", cur_pos, 0);
      chk(cur_neg == 12'hFFF, "R9 neg in reset", cur_neg, 12'hFFF);
      word_in = 12'h000;
      rst = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(cur_pos == 0 && bin_lines == 0 && ladder_lines == 0, "R9 after release", cur_pos, 0);
   endtask

   task automatic t_open(input logic [11:0] c);
      drive(c, 1'b0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_word(c, "R5 open");
   endtask

   task automatic t_latency;
      logic [11:0] prev = cur_pos;
      drive(12'h5A3, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk(cur_pos == prev, "R5 one edge", cur_pos, prev);
      @(posedge clk);
      @(negedge clk);
      chk(cur_pos == 12'h5A3, "R5 two edges", cur_pos, 12'h5A3);
   endtask

   task automatic t_scale;
      t_open(12'hFFF);
      chk(cur_pos == 4095 && cur_neg == 0, "R7 all ones", cur_neg, 0);
      chk(seg_lines == 15'h7FFF, "R7 all lines", seg_lines, 15'h7FFF);
      t_open(12'h000);
      chk(cur_pos == 0 && cur_neg == 4095, "R7 all zeros", cur_neg, 4095);
   endtask

   task automatic t_hold;
      t_open(12'h3C5);
      drive(12'hA5A, 1'b1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_word(12'h3C5, "R6 held");
      drive(12'hFFF, 1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_word(12'h3C5, "R6 still held");
      drive(12'h1E7, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk(cur_pos == 12'h3C5, "R6 strobe delayed", cur_pos, 12'h3C5);
      @(posedge clk);
      @(negedge clk);
      check_word(12'h1E7, "R6 reopened");
   endtask

   task automatic t_edge;
      drive(12'h9B4, 1'b1);
      drive(12'h246, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pos1 == 12'h9B4, "R10 captured word", pos1, 12'h9B4);
      chk(seg1 == therm_of(12'h9B4), "R10 seg", seg1, therm_of(12'h9B4));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pos1 == 12'h9B4, "R10 low-strobe word ignored", pos1, 12'h9B4);
      chk(int'(pos1) + int'(neg1) == 4095, "R10 R8 sum", int'(pos1) + int'(neg1), 4095);
   endtask

   initial begin
      t_reset();
      t_open(12'h123);
      t_open(12'h7FF);
      t_open(12'h800);
      t_open(12'h0C0);
      t_open(12'h03F);
      t_open(12'hE81);
      t_latency();
      t_scale();
      t_hold();
      t_edge();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule